// File: doc/BRIEF.md
# Receive Buffer Writer with Length Checks

This block takes the words of an accepted receive frame and lays them into a memory buffer. The buffer is given at frame start as a base address, split into a high part and a 16-bit low part, and a capacity in words. Each stored word goes to the next address. A carry out of the low part moves into the high part, so a frame can run across 256-word page edges and across a 64K-word boundary.

At frame end the block decides the outcome. A frame that fits and is long enough raises a completion pulse that carries the number of words stored. A frame that arrived with more words than the buffer holds also completes, but reports an all-ones count, and its excess words are never written. A short frame that did not overflow is dropped: the block raises a purge pulse and no completion.

Top module: `rx_buf_writer`

## Requirements
- R1: After reset, and until a frame starts, `wr_en`, `done_pulse` and `purge_pulse` are all low.
- R2: The k-th word accepted in a frame (counting from 0) is written with its data unchanged at address {`base_hi`,`base_lo`} + k. The write appears on the memory port one cycle after the word is presented.
- R3: When the low address part steps past 0xFFFF, the high part increases by one. Stepping past a 256-word page edge continues at the next page without a gap.
- R4: Words that arrive after `buf_words` words have been stored in the frame are not written.
- R5: A frame that had more words than `buf_words` completes with `done_count` = 0xFFFF, whatever its length.
- R6: A frame with no overflow and at least RUNT_MIN (default 6) stored words completes with `done_count` equal to the number of words stored.
- R7: A frame with no overflow and fewer than RUNT_MIN stored words raises `purge_pulse` and does not raise `done_pulse`.
- R8: `word_valid` and `frame_end` have no effect when no frame is open: nothing is written and no pulse is raised.
- R9: `done_pulse` or `purge_pulse` is high for exactly one cycle, the cycle after `frame_end` is sampled. The two are never high together. A word presented together with `frame_end` is stored and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a frame and loads base and capacity |
| base_hi | input | HI_W (8) | High part of the buffer base address |
| base_lo | input | LO_W (16) | Low part of the buffer base address |
| buf_words | input | CNT_W (16) | Buffer capacity in words |
| word_valid | input | 1 | A receive word is present |
| word_data | input | DATA_W (16) | Receive word |
| frame_end | input | 1 | Last cycle of the frame |
| wr_en | output | 1 | Memory write strobe |
| wr_addr_hi | output | HI_W (8) | Write address, high part |
| wr_addr_lo | output | LO_W (16) | Write address, low part |
| wr_data | output | DATA_W (16) | Write data |
| done_pulse | output | 1 | Frame completed |
| done_count | output | CNT_W (16) | Used word count, valid with `done_pulse` |
| purge_pulse | output | 1 | Runt frame dropped |

## Verification
The bench builds the block with its default widths and a runt limit of 6. It sweeps every capacity from 0 to 9 against every frame length from 0 to 11. That covers every length on either side of the runt limit, and every relation of length to capacity: under, equal and over. Each pair runs from three bases: one a few words below a 64K boundary, one just below a 256-word page edge, and zero. This puts both kinds of address carry inside short frames.

// File: rtl/rxw_pkg.sv
// Shared types for the receive buffer writer.
// Assumes nothing beyond standard SystemVerilog.
package rxw_pkg;
    // Outcome of a closed frame.
    typedef enum logic [1:0] {
        OUTCOME_NONE  = 2'd0,
        OUTCOME_DONE  = 2'd1,
        OUTCOME_PURGE = 2'd2
    } outcome_t;
endpackage

// File: rtl/rxw_addr_step.sv
// Write address register for the receive buffer writer.
// Holds a split address {hi, lo}. On load it takes the base. On step the low part
// advances by one, and a carry out of the low part goes into the high part.
// Assumes load and step are never asserted together.
module rxw_addr_step #(
    parameter int LO_W      = 16,
    parameter int HI_W      = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [HI_W-1:0] base_hi,
    input  logic [LO_W-1:0] base_lo,
    output logic [HI_W-1:0] addr_hi,
    output logic [LO_W-1:0] addr_lo,
    output logic            page_cross
);
    localparam logic [PAGE_BITS-1:0] PAGE_LAST = '1;

    logic [LO_W:0]   lo_sum;
    logic [HI_W-1:0] hi_next;

    // Next low address with its carry, and the high part after the carry.
    always_comb begin
        lo_sum  = {1'b0, addr_lo} + {{LO_W{1'b0}}, 1'b1};
        hi_next = addr_hi + {{(HI_W-1){1'b0}}, lo_sum[LO_W]};
    end

    // Flags a step that leaves the last word of a page.
    assign page_cross = step && (addr_lo[PAGE_BITS-1:0] == PAGE_LAST);

    // Address register: reset, load of the base, or single-word step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi <= '0;
            addr_lo <= '0;
        end else if (load) begin
            addr_hi <= base_hi;
            addr_lo <= base_lo;
        end else if (step) begin
            addr_hi <= hi_next;
            addr_lo <= lo_sum[LO_W-1:0];
        end
    end

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross |=> (addr_lo[PAGE_BITS-1:0] == '0)); // R3
    AST_HI_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr_lo == '1) |=> (addr_hi == $past(addr_hi) + 1'b1)); // R3
endmodule

// File: rtl/rxw_room.sv
// Remaining-capacity counter for the receive buffer writer.
// Loads the buffer capacity at frame start and counts down once per stored word.
// Assumes dec is only raised while the counter is not empty.
module rxw_room #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] size,
    output logic [CNT_W-1:0] room,
    output logic             empty
);
    assign empty = (room == '0);

    // Counter: load capacity, or take one word off.
    always_ff @(posedge clk) begin
        if (!rst_n)     room <= '0;
        else if (load)  room <= size;
        else if (dec)   room <= room - 1'b1;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !empty); // R4
endmodule

// File: rtl/rxw_verdict.sv
// End-of-frame judge for the receive buffer writer.
// When fire is raised it turns the capacity, the final remaining room and the
// overflow flag into one registered pulse. The pulse is a completion with the
// used count, or a purge for a runt frame.
// Assumes fire lasts a single cycle per frame.
module rxw_verdict
    import rxw_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RUNT_MIN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             ovf,
    input  logic [CNT_W-1:0] size,
    input  logic [CNT_W-1:0] room,
    output logic             done_pulse,
    output logic [CNT_W-1:0] done_count,
    output logic             purge_pulse
);
    localparam logic [CNT_W-1:0] RUNT_LIM = CNT_W'(RUNT_MIN);

    outcome_t         pick;
    logic [CNT_W-1:0] used;

    // Words stored, then the outcome: overflow wins over the runt check.
    always_comb begin
        used = size - room;
        if (!fire)                 pick = OUTCOME_NONE;
        else if (ovf)              pick = OUTCOME_DONE;
        else if (used < RUNT_LIM)  pick = OUTCOME_PURGE;
        else                       pick = OUTCOME_DONE;
    end

    // Output register: one-cycle pulses and the reported count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse  <= 1'b0;
            purge_pulse <= 1'b0;
            done_count  <= '0;
        end else begin
            done_pulse  <= (pick == OUTCOME_DONE);
            purge_pulse <= (pick == OUTCOME_PURGE);
            if (pick == OUTCOME_DONE) done_count <= ovf ? '1 : used;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && purge_pulse)); // R9
    AST_DONE_NOT_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_count >= RUNT_LIM)); // R7
    AST_OVF_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ovf) |=> (done_pulse && done_count == '1)); // R5
endmodule

// File: rtl/rx_buf_writer.sv
// Receive buffer writer, top level.
// Opens a frame on frame_start and stores each valid word at the next buffer
// address while capacity remains. Words beyond capacity are dropped and mark
// overflow. On frame_end it hands the outcome to the judge.
// Assumes frame_start and frame_end are not raised in the same cycle.
// A word presented with frame_start is ignored.
module rx_buf_writer #(
    parameter int DATA_W    = 16,
    parameter int LO_W      = 16,
    parameter int HI_W      = 8,
    parameter int CNT_W     = 16,
    parameter int PAGE_BITS = 8,
    parameter int RUNT_MIN  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [HI_W-1:0]   base_hi,
    input  logic [LO_W-1:0]   base_lo,
    input  logic [CNT_W-1:0]  buf_words,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              frame_end,
    output logic              wr_en,
    output logic [HI_W-1:0]   wr_addr_hi,
    output logic [LO_W-1:0]   wr_addr_lo,
    output logic [DATA_W-1:0] wr_data,
    output logic              done_pulse,
    output logic [CNT_W-1:0]  done_count,
    output logic              purge_pulse
);
    logic             open_q;
    logic             ovf_q;
    logic [CNT_W-1:0] size_q;
    logic [HI_W-1:0]  cur_hi;
    logic [LO_W-1:0]  cur_lo;
    logic [CNT_W-1:0] room;
    logic             room_empty;
    logic             page_cross;
    logic             accept;
    logic             store;
    logic             spill;
    logic             close;
    logic [CNT_W-1:0] room_final;
    logic             ovf_final;

    // Classify this cycle's word and frame end against the open frame.
    always_comb begin
        accept     = open_q && word_valid && !frame_start;
        store      = accept && !room_empty;
        spill      = accept && room_empty;
        close      = open_q && frame_end && !frame_start;
        room_final = store ? room - 1'b1 : room;
        ovf_final  = ovf_q || spill;
    end

    // Frame state: open flag, overflow flag and latched capacity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            ovf_q  <= 1'b0;
            size_q <= '0;
        end else if (frame_start) begin
            open_q <= 1'b1;
            ovf_q  <= 1'b0;
            size_q <= buf_words;
        end else begin
            if (close) open_q <= 1'b0;
            if (spill) ovf_q  <= 1'b1;
        end
    end

    // Memory write port register: one write per stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr_hi <= '0;
            wr_addr_lo <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= store;
            if (store) begin
                wr_addr_hi <= cur_hi;
                wr_addr_lo <= cur_lo;
                wr_data    <= word_data;
            end
        end
    end

    rxw_addr_step #(
        .LO_W      (LO_W),
        .HI_W      (HI_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (frame_start),
        .step       (store),
        .base_hi    (base_hi),
        .base_lo    (base_lo),
        .addr_hi    (cur_hi),
        .addr_lo    (cur_lo),
        .page_cross (page_cross)
    );

    rxw_room #(
        .CNT_W (CNT_W)
    ) u_room (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .dec   (store),
        .size  (buf_words),
        .room  (room),
        .empty (room_empty)
    );

    rxw_verdict #(
        .CNT_W    (CNT_W),
        .RUNT_MIN (RUNT_MIN)
    ) u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (close),
        .ovf         (ovf_final),
        .size        (size_q),
        .room        (room_final),
        .done_pulse  (done_pulse),
        .done_count  (done_count),
        .purge_pulse (purge_pulse)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !frame_start) |=> (!wr_en && !done_pulse && !purge_pulse)); // R8
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> ({wr_addr_hi, wr_addr_lo} == $past({wr_addr_hi, wr_addr_lo}) + 1'b1)); // R2
    AST_NO_WRITE_PAST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        spill |=> !wr_en); // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse || purge_pulse) |=> !(done_pulse || purge_pulse)); // R9
    AST_PAGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross |-> store); // R3
endmodule

// File: tb/test_rx_buf_writer.sv
module test_rx_buf_writer;
    localparam int CLK_PERIOD = 10;
    localparam int RUNT       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [7:0]  base_hi = '0;
    logic [15:0] base_lo = '0;
    logic [15:0] buf_words = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        frame_end = 1'b0;
    logic        wr_en;
    logic [7:0]  wr_addr_hi;
    logic [15:0] wr_addr_lo;
    logic [15:0] wr_data;
    logic        done_pulse;
    logic [15:0] done_count;
    logic        purge_pulse;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // Monitor state for the current frame.
    int          wr_seen = 0;
    logic [23:0] exp_base = '0;
    logic [15:0] exp_seed = '0;
    int          exp_len = 0;
    int          exp_size = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_buf_writer i_rx_buf_writer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .base_hi(base_hi), .base_lo(base_lo), .buf_words(buf_words),
        .word_valid(word_valid), .word_data(word_data), .frame_end(frame_end),
        .wr_en(wr_en), .wr_addr_hi(wr_addr_hi), .wr_addr_lo(wr_addr_lo),
        .wr_data(wr_data), .done_pulse(done_pulse), .done_count(done_count),
        .purge_pulse(purge_pulse)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Write monitor: every write checked against base + index.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            logic [23:0] ea;
            ea = exp_base + 24'(wr_seen);
            if (ea[23:16] != exp_base[23:16])
                check({wr_addr_hi, wr_addr_lo} == ea, "R3 high carry", {wr_addr_hi, wr_addr_lo}, ea);
            else
                check({wr_addr_hi, wr_addr_lo} == ea, "R2 address", {wr_addr_hi, wr_addr_lo}, ea);
            check(wr_data == (exp_seed ^ 16'(wr_seen)), "R2 data", wr_data, exp_seed ^ 16'(wr_seen));
            check(wr_seen < exp_size && wr_seen < exp_len, "R4 write within capacity", wr_seen, exp_size);
            wr_seen++;
        end
    end

    task automatic run_frame(input logic [7:0] hi, input logic [15:0] lo, input int size, input int len);
        int stored;
        @(negedge clk);
        wr_seen  = 0;
        exp_base = {hi, lo};
        exp_seed = 16'(size * 37 + len * 5 + int'(lo));
        exp_len  = len;
        exp_size = size;
        frame_start = 1'b1; base_hi = hi; base_lo = lo; buf_words = 16'(size);
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            word_valid = 1'b1;
            word_data  = exp_seed ^ 16'(i);
            frame_end  = (i == len - 1);
            @(negedge clk);
        end
        if (len == 0) begin
            frame_end = 1'b1;
            @(negedge clk);
        end
        word_valid = 1'b0; frame_end = 1'b0;
        // Now one cycle past the frame_end edge: the outcome is visible.
        stored = (len < size) ? len : size;
        if (len > size) begin
            check(done_pulse && done_count == 16'hFFFF, "R5 overflow count", done_count, 16'hFFFF);
            check(!purge_pulse, "R5 no purge on overflow", purge_pulse, 0);
        end else if (stored < RUNT) begin
            check(purge_pulse && !done_pulse, "R7 runt purge", {done_pulse, purge_pulse}, 1);
        end else begin
            check(done_pulse && done_count == 16'(stored), "R6 used count", done_count, stored);
            check(!purge_pulse, "R9 exclusive", purge_pulse, 0);
        end
        @(negedge clk);
        check(!done_pulse && !purge_pulse, "R9 single cycle", {done_pulse, purge_pulse}, 0);
        check(wr_seen == stored, (len > size) ? "R4 write total" : "R2 write total", wr_seen, stored);
    endtask

    initial begin
        logic [7:0]  hs[3];
        logic [15:0] ls[3];
        hs[0] = 8'h03; ls[0] = 16'hFFFD;
        hs[1] = 8'h12; ls[1] = 16'h04FE;
        hs[2] = 8'h00; ls[2] = 16'h0000;
        repeat (3) @(negedge clk);
        check(!wr_en && !done_pulse && !purge_pulse, "R1 reset", {wr_en, done_pulse, purge_pulse}, 0);
        rst_n = 1'b1;
        // Idle stimulus before any frame opens.
        exp_size = 0; exp_len = 0; wr_seen = 0;
        word_valid = 1'b1; word_data = 16'h5A5A;
        @(negedge clk);
        check(!wr_en && !done_pulse && !purge_pulse, "R1 quiet after reset", {wr_en, done_pulse, purge_pulse}, 0);
        frame_end = 1'b1;
        @(negedge clk);
        word_valid = 1'b0; frame_end = 1'b0;
        @(negedge clk);
        check(!wr_en && !done_pulse && !purge_pulse, "R8 idle ignored", {wr_en, done_pulse, purge_pulse}, 0);
        check(wr_seen == 0, "R8 idle no write", wr_seen, 0);
        for (int b = 0; b < 3; b++)
            for (int s = 0; s < 10; s++)
                for (int n = 0; n < 12; n++)
                    run_frame(hs[b], ls[b], s, n);
        // Idle after a closed frame: a stray end and word do nothing.
        wr_seen = 0; exp_size = 0;
        word_valid = 1'b1; frame_end = 1'b1;
        @(negedge clk);
        word_valid = 1'b0; frame_end = 1'b0;
        @(negedge clk);
        check(!done_pulse && !purge_pulse && wr_seen == 0, "R8 after close", {done_pulse, purge_pulse}, 0);
        finish_run();
    end
endmodule